// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block brings a flat-panel display up and down in a fixed order. On power-up it switches on the panel logic supply, then the data/control enable, then the backlight. On power-down it drops them in the reverse order. A programmable interval separates each step. All intervals are timed by one shared down-counter that runs on the reference clock and is reloaded with a different delay at each step.

The sequence runs while an interface-enable bit and a start-sequence bit are both set. Clearing either bit starts the power-down. The power-down may interrupt a power-up that is only partly done. Once the logic supply has been switched off, a minimum off time must pass before a new power-up can begin. The delays arrive as plain input ports. The current phase is reported on a two-bit state output.

Top module: `panel_power_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in the idle phase (state code 0) with the supply, data-enable and backlight outputs all low.
- R2: The sequence enable is the AND of `ifEnable` and `seqStart`. If either bit is low in the idle phase with the supply off, nothing changes.
- R3: In the idle phase with the supply off, a high sequence enable raises `panelSupplyOn` at the next clock edge. If the enable stays high, `dataEnable` rises `dlySupplyToData`+1 edges later and the state becomes 1.
- R4: `backlightOn` rises `dlyDataToLight`+1 edges after `dataEnable` rises, provided the enable stays high. The state becomes 2 and stays there while the enable is held. State codes are: 0 idle, 1 data-enabled, 2 backlight on, 3 power-off wait.
- R5: In state 2, a low enable drops `backlightOn` at the next edge and returns the state to 1. `dataEnable` then drops `dlyDataToLight`+1 edges later, so the same delay is used in both directions.
- R6: After `dataEnable` drops, `panelSupplyOn` drops `dlyDataToSupplyOff`+1 edges later and the state becomes 3. If the enable is high when that interval ends, the block holds with `dataEnable` low and the supply on until the enable goes low. It does not re-raise `dataEnable`.
- R7: State 3 ignores the enable. It returns to state 0 `dlyOffToOn`+1 edges after entry, with the supply kept low. A new power-up starts no earlier than the edge after that return.
- R8: In state 0 with the supply on, a low enable drops the supply at the next edge and enters state 3.
- R9: In state 1 during power-up (the backlight never lit), a low enable drops `dataEnable` at the next edge. The state stays 1.
- R10: If the enable returns high while state 1 is waiting out the backlight-to-data-enable interval, `dataEnable` stays high and the backlight relights when that interval ends.
- R11: A delay of zero makes the following step happen at the very next edge.
- R12: `backlightOn` is never high without `dataEnable`, and `dataEnable` is never high without `panelSupplyOn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the counter and the state machine |
| rstN | input | 1 | Active-low synchronous reset |
| ifEnable | input | 1 | Interface enable bit |
| seqStart | input | 1 | Start-sequence bit |
| dlySupplyToData | input | CNT_W | Delay from supply on to data-enable on |
| dlyDataToLight | input | CNT_W | Delay from data-enable on to backlight on, and from backlight off to data-enable off |
| dlyDataToSupplyOff | input | CNT_W | Delay from data-enable off to supply off |
| dlyOffToOn | input | CNT_W | Minimum time the supply stays off |
| panelSupplyOn | output | 1 | Panel logic supply control |
| dataEnable | output | 1 | Data/control enable |
| backlightOn | output | 1 | Backlight control |
| seqState | output | 2 | Current phase (0 idle, 1 data-enabled, 2 backlight, 3 off wait) |

## Verification
The main test runs complete power-up and power-down cycles with four distinct delays. Because the delays differ, a step timed off the wrong delay lands on a different edge and is caught. Three aborts are then applied: one during the first interval, one before the backlight, and one during the reverse interval with the enable raised again. Each abort exercises a different branch of the shared counter's reload logic. Raising the enable while the supply-off interval is still running separates a committed power-down from a restarted one. Zero delays and a mid-sequence reset cover the count boundary and the reset path.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;
  typedef enum logic [1:0] {
    PS_IDLE    = 2'd0,
    PS_DATA    = 2'd1,
    PS_LIGHT   = 2'd2,
    PS_OFFWAIT = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    DLY_SUP_DATA   = 2'd0,
    DLY_DATA_LIGHT = 2'd1,
    DLY_DATA_OFF   = 2'd2,
    DLY_OFF_ON     = 2'd3
  } dly_sel_e;

  typedef struct packed {
    logic     load;
    dly_sel_e sel;
  } cnt_strobe_t;
endpackage

// File: rtl/panel_seq_count.sv
module panel_seq_count
  import panel_seq_pkg::*;
#(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      strobe,
  input  logic [CNT_W-1:0] dlySupplyToData,
  input  logic [CNT_W-1:0] dlyDataToLight,
  input  logic [CNT_W-1:0] dlyDataToSupplyOff,
  input  logic [CNT_W-1:0] dlyOffToOn,
  output logic             cntDone
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] loadValue;

  always_comb begin
    unique case (strobe.sel)
      DLY_SUP_DATA:   loadValue = dlySupplyToData;
      DLY_DATA_LIGHT: loadValue = dlyDataToLight;
      DLY_DATA_OFF:   loadValue = dlyDataToSupplyOff;
      default:        loadValue = dlyOffToOn;
    endcase
  end

  // Load wins over decrement; the count parks at zero instead of wrapping.
  always_ff @(posedge clk) begin
    if (!rstN)                count <= ZERO;
    else if (strobe.load)     count <= loadValue;
    else if (count != ZERO)   count <= count - ONE;
  end

  assign cntDone = (count == ZERO);
endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
  import panel_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        seqEnable,
  input  logic        cntDone,
  output cnt_strobe_t strobe,
  output logic        supplyOn,
  output logic        deOn,
  output logic        blOn,
  output seq_state_e  state
);
  seq_state_e nState;
  logic nSupply, nDe, nBl, unwinding, nUnwinding;

  always_comb begin
    nState     = state;
    nSupply    = supplyOn;
    nDe        = deOn;
    nBl        = blOn;
    nUnwinding = unwinding;
    strobe     = '{load: 1'b0, sel: DLY_SUP_DATA};
    unique case (state)
      PS_IDLE: begin
        if (!supplyOn) begin
          if (seqEnable) begin
            nSupply = 1'b1;
            strobe  = '{load: 1'b1, sel: DLY_SUP_DATA};
          end
        end else if (!seqEnable) begin
          nSupply = 1'b0;
          nState  = PS_OFFWAIT;
          strobe  = '{load: 1'b1, sel: DLY_OFF_ON};
        end else if (cntDone) begin
          nDe    = 1'b1;
          nState = PS_DATA;
          strobe = '{load: 1'b1, sel: DLY_DATA_LIGHT};
        end
      end
      PS_DATA: begin
        if (deOn) begin
          if (!seqEnable && (!unwinding || cntDone)) begin
            nDe        = 1'b0;
            nUnwinding = 1'b0;
            strobe     = '{load: 1'b1, sel: DLY_DATA_OFF};
          end else if (seqEnable && cntDone) begin
            nBl        = 1'b1;
            nUnwinding = 1'b0;
            nState     = PS_LIGHT;
          end
        end else if (cntDone && !seqEnable) begin
          nSupply = 1'b0;
          nState  = PS_OFFWAIT;
          strobe  = '{load: 1'b1, sel: DLY_OFF_ON};
        end
      end
      PS_LIGHT: begin
        if (!seqEnable) begin
          nBl        = 1'b0;
          nUnwinding = 1'b1;
          nState     = PS_DATA;
          strobe     = '{load: 1'b1, sel: DLY_DATA_LIGHT};
        end
      end
      default: begin
        if (cntDone) nState = PS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= PS_IDLE;
      supplyOn  <= 1'b0;
      deOn      <= 1'b0;
      blOn      <= 1'b0;
      unwinding <= 1'b0;
    end else begin
      state     <= nState;
      supplyOn  <= nSupply;
      deOn      <= nDe;
      blOn      <= nBl;
      unwinding <= nUnwinding;
    end
  end
endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
  import panel_seq_pkg::*;
#(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ifEnable,
  input  logic             seqStart,
  input  logic [CNT_W-1:0] dlySupplyToData,
  input  logic [CNT_W-1:0] dlyDataToLight,
  input  logic [CNT_W-1:0] dlyDataToSupplyOff,
  input  logic [CNT_W-1:0] dlyOffToOn,
  output logic             panelSupplyOn,
  output logic             dataEnable,
  output logic             backlightOn,
  output logic [1:0]       seqState
);
  cnt_strobe_t strobe;
  seq_state_e  state;
  logic        cntDone;
  logic        seqEnable;

  assign seqEnable = ifEnable & seqStart;

  panel_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .seqEnable (seqEnable),
    .cntDone   (cntDone),
    .strobe    (strobe),
    .supplyOn  (panelSupplyOn),
    .deOn      (dataEnable),
    .blOn      (backlightOn),
    .state     (state)
  );

  panel_seq_count #(.CNT_W(CNT_W)) u_count (
    .clk                (clk),
    .rstN               (rstN),
    .strobe             (strobe),
    .dlySupplyToData    (dlySupplyToData),
    .dlyDataToLight     (dlyDataToLight),
    .dlyDataToSupplyOff (dlyDataToSupplyOff),
    .dlyOffToOn         (dlyOffToOn),
    .cntDone            (cntDone)
  );

  assign seqState = state;
endmodule

// File: rtl/panel_seq_chk.sv
module panel_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ifEnable,
  input logic       seqStart,
  input logic       supplyOn,
  input logic       dataEnable,
  input logic       backlightOn,
  input logic [1:0] seqState
);
  // R12
  bl_needs_de_chk: assert property (@(posedge clk) disable iff (!rstN)
    backlightOn |-> dataEnable);

  // R12
  de_needs_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataEnable |-> supplyOn);

  // R4
  light_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    backlightOn |-> seqState == 2'd2);

  // R7
  offwait_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqState == 2'd3 |-> (!supplyOn && !dataEnable));

  // R3
  supply_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supplyOn) |-> ($past(seqState) == 2'd0 && $past(ifEnable && seqStart)));

  // R7
  offwait_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState != 2'd3 && $past(seqState) == 2'd3) |-> seqState == 2'd0);

  // R8
  idle_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(seqState) == 2'd0 && $past(supplyOn) && !$past(ifEnable && seqStart))
      |-> (seqState == 2'd3 && !supplyOn));
endmodule

bind panel_power_seq panel_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ifEnable    (ifEnable),
  .seqStart    (seqStart),
  .supplyOn    (panelSupplyOn),
  .dataEnable  (dataEnable),
  .backlightOn (backlightOn),
  .seqState    (seqState)
);

// File: tb/panel_power_seq_tb.sv
module panel_power_seq_tb;
  localparam int CNT_W = 26;
  localparam int NVEC  = 30;

  // {ifEnable, seqStart, edges[7:0], supply, de, bl, state[1:0], req[3:0]}
  localparam logic [18:0] VECS [NVEC] = '{
    {1'b1,1'b0,8'd3, 1'b0,1'b0,1'b0,2'd0,4'd2},   // R2
    {1'b0,1'b1,8'd2, 1'b0,1'b0,1'b0,2'd0,4'd2},   // R2
    {1'b1,1'b1,8'd1, 1'b1,1'b0,1'b0,2'd0,4'd3},   // R3
    {1'b1,1'b1,8'd3, 1'b1,1'b0,1'b0,2'd0,4'd3},   // R3
    {1'b1,1'b1,8'd1, 1'b1,1'b1,1'b0,2'd1,4'd3},   // R3
    {1'b1,1'b1,8'd2, 1'b1,1'b1,1'b0,2'd1,4'd4},   // R4
    {1'b1,1'b1,8'd1, 1'b1,1'b1,1'b1,2'd2,4'd4},   // R4
    {1'b1,1'b1,8'd10,1'b1,1'b1,1'b1,2'd2,4'd4},   // R4
    {1'b1,1'b0,8'd1, 1'b1,1'b1,1'b0,2'd1,4'd5},   // R5
    {1'b1,1'b0,8'd2, 1'b1,1'b1,1'b0,2'd1,4'd5},   // R5
    {1'b1,1'b0,8'd1, 1'b1,1'b0,1'b0,2'd1,4'd5},   // R5
    {1'b1,1'b0,8'd4, 1'b1,1'b0,1'b0,2'd1,4'd6},   // R6
    {1'b1,1'b0,8'd1, 1'b0,1'b0,1'b0,2'd3,4'd6},   // R6
    {1'b1,1'b1,8'd5, 1'b0,1'b0,1'b0,2'd3,4'd7},   // R7
    {1'b1,1'b1,8'd1, 1'b0,1'b0,1'b0,2'd0,4'd7},   // R7
    {1'b1,1'b1,8'd1, 1'b1,1'b0,1'b0,2'd0,4'd7},   // R7
    {1'b1,1'b0,8'd1, 1'b0,1'b0,1'b0,2'd3,4'd8},   // R8
    {1'b0,1'b0,8'd6, 1'b0,1'b0,1'b0,2'd0,4'd8},   // R8
    {1'b1,1'b1,8'd1, 1'b1,1'b0,1'b0,2'd0,4'd3},   // R3
    {1'b1,1'b1,8'd4, 1'b1,1'b1,1'b0,2'd1,4'd3},   // R3
    {1'b1,1'b0,8'd1, 1'b1,1'b0,1'b0,2'd1,4'd9},   // R9
    {1'b1,1'b1,8'd6, 1'b1,1'b0,1'b0,2'd1,4'd6},   // R6
    {1'b0,1'b1,8'd1, 1'b0,1'b0,1'b0,2'd3,4'd6},   // R6
    {1'b0,1'b0,8'd6, 1'b0,1'b0,1'b0,2'd0,4'd7},   // R7
    {1'b1,1'b1,8'd1, 1'b1,1'b0,1'b0,2'd0,4'd3},   // R3
    {1'b1,1'b1,8'd4, 1'b1,1'b1,1'b0,2'd1,4'd3},   // R3
    {1'b1,1'b1,8'd3, 1'b1,1'b1,1'b1,2'd2,4'd4},   // R4
    {1'b1,1'b0,8'd1, 1'b1,1'b1,1'b0,2'd1,4'd5},   // R5
    {1'b1,1'b1,8'd1, 1'b1,1'b1,1'b0,2'd1,4'd10},  // R10
    {1'b1,1'b1,8'd2, 1'b1,1'b1,1'b1,2'd2,4'd10}   // R10
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ifEnable = 1'b0;
  logic seqStart = 1'b0;
  logic [CNT_W-1:0] dlySupplyToData = 26'd3;
  logic [CNT_W-1:0] dlyDataToLight = 26'd2;
  logic [CNT_W-1:0] dlyDataToSupplyOff = 26'd4;
  logic [CNT_W-1:0] dlyOffToOn = 26'd5;
  logic panelSupplyOn, dataEnable, backlightOn;
  logic [1:0] seqState;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  panel_power_seq #(.CNT_W(CNT_W)) u_dut (
    .clk                (clk),
    .rstN               (rstN),
    .ifEnable           (ifEnable),
    .seqStart           (seqStart),
    .dlySupplyToData    (dlySupplyToData),
    .dlyDataToLight     (dlyDataToLight),
    .dlyDataToSupplyOff (dlyDataToSupplyOff),
    .dlyOffToOn         (dlyOffToOn),
    .panelSupplyOn      (panelSupplyOn),
    .dataEnable         (dataEnable),
    .backlightOn        (backlightOn),
    .seqState           (seqState)
  );

  task automatic checkOut(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {panelSupplyOn, dataEnable, backlightOn, seqState};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {supply,de,bl,state} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOrder(input string req);
    nChecks++;
    if ((backlightOn && !dataEnable) || (dataEnable && !panelSupplyOn)) begin
      nFails++;
      $display("FAIL %s: ordering actual bl=%b de=%b supply=%b expected bl->de->supply",
               req, backlightOn, dataEnable, panelSupplyOn);
    end
  endtask

  task automatic step(input logic ie, input logic ss, input int edges);
    ifEnable = ie;
    seqStart = ss;
    repeat (edges) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    ifEnable = 1'b0;
    seqStart = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    doReset();
    checkOut("R1", 5'b000_00);
    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i][18], VECS[i][17], int'(VECS[i][16:9]));
      checkOut($sformatf("R%0d vec%0d", VECS[i][3:0], i), VECS[i][8:4]);
      checkOrder("R12");
    end

    // R1: reset while backlight is on
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkOut("R1 reset mid-sequence", 5'b000_00);
    rstN = 1'b1;
    step(1'b0, 1'b0, 2);
    checkOut("R1 after release", 5'b000_00);

    // R11: zero delays step on consecutive edges
    dlySupplyToData = '0;
    dlyDataToLight = '0;
    step(1'b1, 1'b1, 1);
    checkOut("R11 supply", 5'b100_00);
    step(1'b1, 1'b1, 1);
    checkOut("R11 data enable", 5'b110_01);
    step(1'b1, 1'b1, 1);
    checkOut("R11 backlight", 5'b111_10);
    step(1'b1, 1'b0, 1);
    checkOut("R11 backlight off", 5'b110_01);
    step(1'b1, 1'b0, 1);
    checkOut("R11 data enable off", 5'b100_01);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule